// File: doc/BRIEF.md
# Watchdog and Alarm Down Counter

A 24-bit down counter that firmware can use either as a repeating alarm or as a one-shot watchdog. It is programmed through byte-wide register strobes. Three counter bytes are followed by a control byte and a status byte. A separate seed register keeps the last programmed value so that the counter can reload itself. Two prescaled enables are supplied from outside: one pulses once per second and the other pulses 4096 times per second. The mode bit chooses which of the two the counter uses.

In alarm mode the counter reloads from the seed each time it reaches zero and raises an alarm flag. In watchdog mode it stops at zero, raises the flag, and can start a fixed-length active-low pulse on either a reset output or an interrupt output. While the reset pulse is active, register access is refused. Any read or write of a counter byte restarts the count from the seed. Firmware uses this to service the watchdog.

Top module: `wdalm_counter`

## Requirements
- R1: Writes to address 4 (bits 7:0) and address 5 (bits 15:8) only stage a byte. A write to address 6 (bits 23:16) loads the staged value into both the counter and the seed in the same cycle.
- R2: With the enable bit (control bit 6) at 0, the counter never decrements. The three bytes behave as plain storage.
- R3: With enable 1 and the mode bit (control bit 5) at 0, the counter decrements only on 1 Hz ticks. When it steps from 1 to 0 it sets the alarm flag (status bit 0) and reloads from the seed.
- R4: With enable 1 and mode 1, the counter decrements only on 4096 Hz ticks. When it steps from 1 to 0 it sets the alarm flag and holds at zero.
- R5: A counter holding zero while enabled does not count and does not set the alarm flag.
- R6: A watchdog-mode alarm with the output-select bit (control bit 3) at 0 asserts `rst_drive_low` and `access_block` for PULSE_TICKS 4096 Hz ticks. During that time writes are ignored and reads return 0. When the pulse ends, both outputs are released and the flag is cleared.
- R7: A watchdog-mode alarm with output-select 1 and interrupt-enable (control bit 0) at 1 asserts `int_drive_low` for PULSE_TICKS ticks. Writing 0 to the flag or to interrupt-enable does not shorten the pulse. When the pulse ends, the flag clears.
- R8: A counter write made during a pulse is stored. The counter does not decrement until the pulse ends.
- R9: A read or write of any counter byte (addresses 4 to 6) reloads the counter from the seed.
- R10: Read data appears on `reg_rdata` one cycle after the read strobe. Reading address 4 returns the live low byte and snapshots the whole counter; addresses 5 and 6 return bytes of that snapshot. Address 7 returns the control byte and address 8 returns {7'b0, flag}. Writing 0 to status bit 0 clears the flag when no pulse is running.
- R11: In alarm mode, `int_drive_low` follows the flag while output-select and interrupt-enable are both 1.
- R12: After reset, all registers are zero and all outputs are deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle enable, once per second |
| tick_4khz | input | 1 | One-cycle enable, 4096 times per second |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| rst_drive_low | output | 1 | Pull the reset line low |
| int_drive_low | output | 1 | Pull the interrupt line low |
| access_block | output | 1 | Register access refused |

## Verification
A corrupted count or seed shows up at the next read of address 4 after that read's single cycle of latency. It also shows up as an alarm that fires at the wrong tick, which the status byte and the pulse outputs expose within one cycle of that tick. A pulse-length counter that drifts is seen as `rst_drive_low` or `int_drive_low` releasing one tick early or late. A wrong gate on the decrement during a pulse is seen as a changed count at the first read after the pulse ends.

// File: rtl/wdalm_counter.sv
module wdalm_counter #(
  parameter int PULSE_TICKS = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       tick_4khz,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       rst_drive_low,
  output logic       int_drive_low,
  output logic       access_block
);
  localparam int PW = $clog2(PULSE_TICKS + 1);
  localparam logic [PW-1:0] PLAST = PW'(PULSE_TICKS - 1);

  logic [23:0]   cnt, seed, snap;
  logic [15:0]   stage;
  logic [7:0]    ctrl;
  logic          af, pulse_rst, pulse_int;
  logic [PW-1:0] pcnt;

  wire en      = ctrl[6];
  wire oneshot = ctrl[5];
  wire sel_int = ctrl[3];
  wire aie     = ctrl[0];

  wire pulsing   = pulse_rst | pulse_int;
  wire wr        = reg_wr & ~pulse_rst;
  wire rd        = reg_rd & ~pulse_rst;
  wire cnt_reg   = (reg_addr >= 4'h4) && (reg_addr <= 4'h6);
  wire touch     = (wr | rd) & cnt_reg;
  wire commit    = wr && reg_addr == 4'h6;
  wire tick      = oneshot ? tick_4khz : tick_1hz;
  wire step      = en && !pulsing && tick && cnt != 24'd0;
  wire fire      = step && cnt == 24'd1;
  wire pulse_end = pulsing && tick_4khz && pcnt == PLAST;

  assign rst_drive_low = pulse_rst;
  assign access_block  = pulse_rst;
  assign int_drive_low = pulse_int | (!oneshot & sel_int & aie & af);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; seed <= '0; snap <= '0; stage <= '0; ctrl <= '0;
      af <= 1'b0; pulse_rst <= 1'b0; pulse_int <= 1'b0; pcnt <= '0;
      reg_rdata <= '0;
    end else begin
      if (commit) begin
        cnt  <= {reg_wdata, stage};
        seed <= {reg_wdata, stage};
      end else if (touch) begin
        cnt <= seed;
      end else if (step) begin
        cnt <= (fire && !oneshot) ? seed : cnt - 24'd1;
      end

      if (wr && reg_addr == 4'h4) stage[7:0]  <= reg_wdata;
      if (wr && reg_addr == 4'h5) stage[15:8] <= reg_wdata;
      if (wr && reg_addr == 4'h7) ctrl        <= reg_wdata;

      if (pulse_end)
        af <= 1'b0;
      else if (fire)
        af <= 1'b1;
      else if (wr && reg_addr == 4'h8 && !reg_wdata[0] && !pulsing)
        af <= 1'b0;

      if (fire && oneshot) begin
        pcnt <= '0;
        if (!sel_int)  pulse_rst <= 1'b1;
        else if (aie)  pulse_int <= 1'b1;
      end else if (pulsing && tick_4khz) begin
        pcnt <= pcnt + 1'b1;
        if (pulse_end) begin
          pulse_rst <= 1'b0;
          pulse_int <= 1'b0;
        end
      end

      if (reg_rd) begin
        if (!rd) reg_rdata <= '0;
        else begin
          case (reg_addr)
            4'h4: begin reg_rdata <= cnt[7:0]; snap <= cnt; end
            4'h5: reg_rdata <= snap[15:8];
            4'h6: reg_rdata <= snap[23:16];
            4'h7: reg_rdata <= ctrl;
            4'h8: reg_rdata <= {7'b0, af};
            default: reg_rdata <= '0;
          endcase
        end
      end
    end
  end

  p_seed_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 4'h6 && !access_block) |=> $stable(seed));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !reg_rd) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 24'd1 || cnt == seed));

  p_hold_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && oneshot && cnt == 24'd0 && !reg_wr && !reg_rd) |=> cnt == 24'd0);

  p_pulse_has_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_rst || pulse_int) |-> af);

  p_blocked_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (access_block && reg_rd) |=> reg_rdata == 8'd0);

  p_one_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pulse_rst && pulse_int));
endmodule

// File: tb/wdalm_counter_tb.sv
module wdalm_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_1hz = 0, tick_4khz = 0, reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic rst_drive_low, int_drive_low, access_block;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdalm_counter #(.PULSE_TICKS(PT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_4khz(tick_4khz),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rst_drive_low(rst_drive_low),
    .int_drive_low(int_drive_low), .access_block(access_block));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0;
    @(negedge clk);
  endtask

  task automatic wcnt(input logic [23:0] v);
    wr(4'h4, v[7:0]); wr(4'h5, v[15:8]); wr(4'h6, v[23:16]);
  endtask

  task automatic t4(input int n);
    for (int i = 0; i < n; i++) begin tick_4khz = 1; @(negedge clk); tick_4khz = 0; end
  endtask

  task automatic t1(input int n);
    for (int i = 0; i < n; i++) begin tick_1hz = 1; @(negedge clk); tick_1hz = 0; end
  endtask

  initial begin
    repeat (CLK_PERIOD * 5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 rdata", reg_rdata, 0);
    chk("R12 outputs", {rst_drive_low, int_drive_low, access_block}, 0);
    rd(4'h8, 8'h00, "R12 status");
    rd(4'h7, 8'h00, "R12 control");

    wcnt(24'h332211);
    t1(3); t4(3);
    rd(4'h4, 8'h11, "R2 byte0 kept");
    rd(4'h5, 8'h22, "R2 byte1 kept");
    rd(4'h6, 8'h33, "R2 byte2 kept");
    wr(4'h4, 8'hAA);
    rd(4'h4, 8'h11, "R1 staged only");
    wr(4'h5, 8'hBB); wr(4'h6, 8'hCC);
    rd(4'h4, 8'hAA, "R1 commit b0");
    rd(4'h5, 8'hBB, "R1 commit b1");
    rd(4'h6, 8'hCC, "R10 snapshot b2");

    wr(4'h7, 8'h40);
    wcnt(24'd3);
    t1(2); t4(5);
    rd(4'h4, 8'h01, "R3 1Hz only");
    t1(2);
    rd(4'h8, 8'h00, "R9 reload by read");
    t1(1);
    rd(4'h8, 8'h01, "R3 alarm flag");
    rd(4'h4, 8'h03, "R3 reload seed");
    chk("R11 int off sel0", int_drive_low, 0);
    wr(4'h7, 8'h49);
    chk("R11 level int", int_drive_low, 1);
    wr(4'h8, 8'h00);
    chk("R10 flag cleared int", int_drive_low, 0);
    rd(4'h8, 8'h00, "R10 flag cleared");

    wcnt(24'd0);
    t1(5);
    rd(4'h8, 8'h00, "R5 no flag");
    rd(4'h4, 8'h00, "R5 still zero");

    wr(4'h7, 8'h60);
    wcnt(24'd2);
    t1(4);
    t4(1);
    chk("R4 not yet", rst_drive_low, 0);
    t4(1);
    chk("R6 rst pulse", rst_drive_low, 1);
    chk("R6 block", access_block, 1);
    rd(4'h8, 8'h00, "R6 blocked read");
    wr(4'h6, 8'h55);
    t4(PT - 1);
    chk("R6 still low", rst_drive_low, 1);
    t4(1);
    chk("R6 released", {rst_drive_low, access_block}, 0);
    rd(4'h8, 8'h00, "R6 flag cleared");
    rd(4'h4, 8'h00, "R4 held zero");
    t4(1);
    rd(4'h4, 8'h01, "R6 write ignored");

    wr(4'h7, 8'h69);
    wcnt(24'd1);
    t4(1);
    chk("R7 int pulse", int_drive_low, 1);
    chk("R7 no block", access_block, 0);
    wr(4'h8, 8'h00); wr(4'h7, 8'h68);
    chk("R7 not cut", int_drive_low, 1);
    rd(4'h8, 8'h01, "R7 flag kept");
    wcnt(24'd5);
    t4(PT - 1);
    chk("R7 still low", int_drive_low, 1);
    rd(4'h4, 8'h05, "R8 frozen");
    t4(1);
    chk("R7 released", int_drive_low, 0);
    rd(4'h8, 8'h00, "R7 flag cleared");
    t4(1);
    rd(4'h4, 8'h04, "R8 resumed");

    wcnt(24'd3);
    t4(2);
    wr(4'h5, 8'h00);
    t4(2);
    rd(4'h8, 8'h00, "R9 reload by write");
    t4(1);
    rd(4'h8, 8'h01, "R4 fired no pulse");
    chk("R4 no pulse", {rst_drive_low, int_drive_low}, 0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule